// File: doc/BRIEF.md
# Corner-Programmed Raster Timing Generator

This block produces raster timing for a display pipeline from corner coordinates kept in registers, rather than from porch and pulse lengths. Two 13-bit counters sweep a frame: X runs from zero to a programmed frame corner, then wraps and steps Y. Y wraps in the same way after its own corner. Each cycle the block compares the position with a display window and with one window per plane channel. It drives horizontal and vertical sync, a display-enable and one active flag per channel, together with the position that these flags belong to.

Software loads the corners through a single-cycle write port. Each corner is a 32-bit word that holds X and Y. A display window corner is stored as "first active coordinate minus one", so a position counts as inside when it lies strictly past the upper-left corner and no further than the lower-right corner. A run bit in the control word moves a two-state machine between HALT, where the counters sit at zero and every output is low, and SCAN, where the counters sweep the frame. The transition HALT→SCAN is taken when the run bit is one. The transition SCAN→HALT is taken when it is zero.

Top module: `corner_raster_gen`

## Requirements
- R1: A write with `wr_en` high stores `wr_data` at byte address `wr_addr`. The control word is at 0x00, the frame corner at 0x04, the display upper-left at 0x08 and the display lower-right at 0x0C. Channel n (1..3) has its top-left corner at 0x10+8·(n−1) and its bottom-right corner 4 bytes later. The sync lengths are at 0x28. Every corner word carries X in bits 12:0 and Y in bits 28:16.
- R2: In the control word, bit 8 is the run bit. Channel 1 is enabled by bit 2, channel 2 by bit 1 and channel 3 by bit 0.
- R3: While scanning, X increments each cycle and returns to 0 after equalling the frame corner X. Y increments on each X return and returns to 0 after the frame corner Y.
- R4: While the run bit is clear, the counters are held at 0 and all outputs are 0. After a restart, the sweep begins again at (0,0).
- R5: `de_o` is high when the displayed position is strictly greater than the display upper-left corner and less than or equal to the display lower-right corner, on both axes.
- R6: `win_act_o[n-1]` is high when channel n is enabled and the position lies inside that channel's corners, using the same rule as R5.
- R7: A channel whose two corner words are both zero is empty and never active. A channel with a zero top-left corner and a non-zero bottom-right corner is not empty.
- R8: `hsync_o` is high while X is less than the X field of the sync-length word, and `vsync_o` is high while Y is less than its Y field.
- R9: All outputs are registered and describe the counter value of the previous cycle, with one common latency. Position (0,0) appears on the outputs after the second rising edge that follows the edge that writes the run bit.
- R10: The state machine enters SCAN on the edge after the run bit reads one, and enters HALT on the edge after it reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 32 | Register write data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Display window active |
| win_act_o | output | 3 | Per-channel window active, bit 0 is channel 1 |
| pos_x_o | output | 13 | X position the outputs refer to |
| pos_y_o | output | 13 | Y position the outputs refer to |

## Verification
The assertions check on every cycle the following properties: the state machine follows the run bit, and the counters step, wrap and stay at zero in HALT. They also check that the outputs are quiet after a halted cycle, that sync and display-enable never rise outside the bounds the registers set, and that disabled or empty channels stay silent. The exact shape of the windows is shown only by the bench's scenarios. So is the restart at (0,0) after a stop, as well as the behaviour of a zero top-left corner with a non-zero bottom-right corner. The bench compares whole frames against positions it predicts itself, for three different register setups.

// File: rtl/crg_pkg.sv
package crg_pkg;

    localparam int COORD_W   = 13;
    localparam int X_LSB     = 0;
    localparam int Y_LSB     = 16;
    localparam int RUN_BIT   = 8;

    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_FRAME   = 'h04;
    localparam int OFS_DISP_UL = 'h08;
    localparam int OFS_DISP_LR = 'h0C;
    localparam int OFS_CH_BASE = 'h10;
    localparam int CH_STRIDE   = 8;
    localparam int CH_BR_STEP  = 4;

    typedef struct packed {
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] x;
    } corner_t;

    typedef enum logic [0:0] {
        ST_HALT = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

    function automatic corner_t unpack_corner(input logic [31:0] word);
        corner_t c;
        c.x = word[X_LSB +: COORD_W];
        c.y = word[Y_LSB +: COORD_W];
        return c;
    endfunction

    // Inside: strictly past upper-left, no further than lower-right.
    function automatic logic in_window(input logic [COORD_W-1:0] px,
                                       input logic [COORD_W-1:0] py,
                                       input corner_t ul,
                                       input corner_t lr);
        return (px > ul.x) && (px <= lr.x) && (py > ul.y) && (py <= lr.y);
    endfunction

endpackage

// File: rtl/crg_regs.sv
module crg_regs
    import crg_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    output logic              run_o,
    output logic [NUM_CH-1:0] ch_en_o,
    output corner_t           frame_o,
    output corner_t           disp_ul_o,
    output corner_t           disp_lr_o,
    output corner_t           sync_len_o,
    output corner_t           ch_tl_o [NUM_CH],
    output corner_t           ch_br_o [NUM_CH]
);

    localparam int SYNC_OFS = OFS_CH_BASE + CH_STRIDE * NUM_CH;

    corner_t           wr_corner;
    logic [NUM_CH-1:0] en_field;
    logic              hit_ctrl;
    logic              hit_frame;
    logic              hit_ul;
    logic              hit_lr;
    logic              hit_sync;
    logic              unused_bits;

    assign wr_corner   = unpack_corner(wr_data);
    assign hit_ctrl    = wr_en && (wr_addr == ADDR_W'(OFS_CTRL));
    assign hit_frame   = wr_en && (wr_addr == ADDR_W'(OFS_FRAME));
    assign hit_ul      = wr_en && (wr_addr == ADDR_W'(OFS_DISP_UL));
    assign hit_lr      = wr_en && (wr_addr == ADDR_W'(OFS_DISP_LR));
    assign hit_sync    = wr_en && (wr_addr == ADDR_W'(SYNC_OFS));
    assign unused_bits = ^{wr_data[31:29], wr_data[15:13]};

    // Channel 1 owns the highest enable bit, the last channel bit 0.
    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            en_field[i] = wr_data[NUM_CH-1-i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_o   <= 1'b0;
            ch_en_o <= '0;
        end else if (hit_ctrl) begin
            run_o   <= wr_data[RUN_BIT];
            ch_en_o <= en_field;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_o    <= '0;
            disp_ul_o  <= '0;
            disp_lr_o  <= '0;
            sync_len_o <= '0;
        end else begin
            if (hit_frame) frame_o    <= wr_corner;
            if (hit_ul)    disp_ul_o  <= wr_corner;
            if (hit_lr)    disp_lr_o  <= wr_corner;
            if (hit_sync)  sync_len_o <= wr_corner;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_regs
        localparam int TL_OFS = OFS_CH_BASE + CH_STRIDE * g;
        localparam int BR_OFS = TL_OFS + CH_BR_STEP;

        logic hit_tl;
        logic hit_br;

        assign hit_tl = wr_en && (wr_addr == ADDR_W'(TL_OFS));
        assign hit_br = wr_en && (wr_addr == ADDR_W'(BR_OFS));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_tl_o[g] <= '0;
                ch_br_o[g] <= '0;
            end else begin
                if (hit_tl) ch_tl_o[g] <= wr_corner;
                if (hit_br) ch_br_o[g] <= wr_corner;
            end
        end
    end

endmodule

// File: rtl/crg_scan_fsm.sv
module crg_scan_fsm
    import crg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  corner_t            frame_i,
    output logic               scan_o,
    output logic [COORD_W-1:0] x_o,
    output logic [COORD_W-1:0] y_o
);

    scan_state_e state_q;
    scan_state_e state_d;
    logic        x_end;
    logic        y_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (run_i)  state_d = ST_SCAN;
            ST_SCAN: if (!run_i) state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    assign scan_o = (state_q == ST_SCAN);

    // ">=" lets a frame corner shrunk during a sweep still wrap at once.
    assign x_end = (x_o >= frame_i.x);
    assign y_end = (y_o >= frame_i.y);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
        end else begin
            unique case (state_q)
                ST_HALT: begin
                    x_o <= '0;
                    y_o <= '0;
                end
                ST_SCAN: begin
                    if (x_end) begin
                        x_o <= '0;
                        y_o <= y_end ? '0 : y_o + 1'b1;
                    end else begin
                        x_o <= x_o + 1'b1;
                    end
                end
                default: begin
                    x_o <= '0;
                    y_o <= '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/crg_window.sv
module crg_window
    import crg_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scan_i,
    input  logic [COORD_W-1:0] x_i,
    input  logic [COORD_W-1:0] y_i,
    input  corner_t            disp_ul_i,
    input  corner_t            disp_lr_i,
    input  corner_t            sync_len_i,
    input  logic [NUM_CH-1:0]  ch_en_i,
    input  corner_t            ch_tl_i [NUM_CH],
    input  corner_t            ch_br_i [NUM_CH],
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [NUM_CH-1:0]  win_o,
    output logic [COORD_W-1:0] x_o,
    output logic [COORD_W-1:0] y_o
);

    logic              hs_d;
    logic              vs_d;
    logic              de_d;
    logic [NUM_CH-1:0] win_d;

    assign hs_d = (x_i < sync_len_i.x);
    assign vs_d = (y_i < sync_len_i.y);
    assign de_d = in_window(x_i, y_i, disp_ul_i, disp_lr_i);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_hit
        logic empty;
        assign empty    = (ch_tl_i[g] == '0) && (ch_br_i[g] == '0);
        assign win_d[g] = ch_en_i[g] && !empty &&
                          in_window(x_i, y_i, ch_tl_i[g], ch_br_i[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            win_o   <= '0;
            x_o     <= '0;
            y_o     <= '0;
        end else if (scan_i) begin
            hsync_o <= hs_d;
            vsync_o <= vs_d;
            de_o    <= de_d;
            win_o   <= win_d;
            x_o     <= x_i;
            y_o     <= y_i;
        end else begin
            hsync_o <= 1'b0;
            vsync_o <= 1'b0;
            de_o    <= 1'b0;
            win_o   <= '0;
            x_o     <= '0;
            y_o     <= '0;
        end
    end

endmodule

// File: rtl/corner_raster_gen.sv
module corner_raster_gen
    import crg_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int ADDR_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [31:0]        wr_data,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               de_o,
    output logic [NUM_CH-1:0]  win_act_o,
    output logic [COORD_W-1:0] pos_x_o,
    output logic [COORD_W-1:0] pos_y_o
);

    logic               run_bit;
    logic [NUM_CH-1:0]  ch_en;
    corner_t            frame_c;
    corner_t            disp_ul;
    corner_t            disp_lr;
    corner_t            sync_c;
    corner_t            ch_tl [NUM_CH];
    corner_t            ch_br [NUM_CH];
    logic               scan_on;
    logic [COORD_W-1:0] cnt_x;
    logic [COORD_W-1:0] cnt_y;

    crg_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .run_o      (run_bit),
        .ch_en_o    (ch_en),
        .frame_o    (frame_c),
        .disp_ul_o  (disp_ul),
        .disp_lr_o  (disp_lr),
        .sync_len_o (sync_c),
        .ch_tl_o    (ch_tl),
        .ch_br_o    (ch_br)
    );

    crg_scan_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (run_bit),
        .frame_i (frame_c),
        .scan_o  (scan_on),
        .x_o     (cnt_x),
        .y_o     (cnt_y)
    );

    crg_window #(.NUM_CH(NUM_CH)) u_win (
        .clk        (clk),
        .rst_n      (rst_n),
        .scan_i     (scan_on),
        .x_i        (cnt_x),
        .y_i        (cnt_y),
        .disp_ul_i  (disp_ul),
        .disp_lr_i  (disp_lr),
        .sync_len_i (sync_c),
        .ch_en_i    (ch_en),
        .ch_tl_i    (ch_tl),
        .ch_br_i    (ch_br),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .de_o       (de_o),
        .win_o      (win_act_o),
        .x_o        (pos_x_o),
        .y_o        (pos_y_o)
    );

endmodule

// File: rtl/crg_checker.sv
module crg_checker
    import crg_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_i,
    input logic               scan_i,
    input logic [COORD_W-1:0] cnt_x_i,
    input logic [COORD_W-1:0] cnt_y_i,
    input corner_t            frame_i,
    input corner_t            disp_ul_i,
    input corner_t            disp_lr_i,
    input corner_t            sync_i,
    input logic [NUM_CH-1:0]  ch_en_i,
    input corner_t            ch_tl_i [NUM_CH],
    input corner_t            ch_br_i [NUM_CH],
    input logic               hsync_i,
    input logic               vsync_i,
    input logic               de_i,
    input logic [NUM_CH-1:0]  win_i,
    input logic [COORD_W-1:0] pos_x_i,
    input logic [COORD_W-1:0] pos_y_i
);

    assert_enter_scan_R10: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |=> scan_i);

    assert_enter_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !scan_i);

    assert_halt_counters_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_i |=> (cnt_x_i == '0) && (cnt_y_i == '0));

    assert_halt_outputs_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_i |=> !hsync_i && !vsync_i && !de_i && (win_i == '0));

    assert_x_wraps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_i && cnt_x_i >= frame_i.x) |=> (cnt_x_i == '0));

    assert_x_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_i && run_i && cnt_x_i < frame_i.x) |=> (cnt_x_i == $past(cnt_x_i) + 13'd1));

    assert_y_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_i && run_i && cnt_x_i >= frame_i.x && cnt_y_i < frame_i.y)
        |=> (cnt_y_i == $past(cnt_y_i) + 13'd1));

    assert_pos_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        scan_i |=> (pos_x_i == $past(cnt_x_i)) && (pos_y_i == $past(cnt_y_i)));

    assert_hsync_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hsync_i |-> ($past(cnt_x_i) < $past(sync_i.x)));

    assert_vsync_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |-> ($past(cnt_y_i) < $past(sync_i.y)));

    assert_de_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        de_i |-> ($past(cnt_x_i) > $past(disp_ul_i.x)) && ($past(cnt_x_i) <= $past(disp_lr_i.x)));

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch_chk
        assert_win_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            win_i[g] |-> $past(ch_en_i[g]));

        assert_empty_window_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $past((ch_tl_i[g] == '0) && (ch_br_i[g] == '0)) |-> !win_i[g]);
    end

endmodule

bind corner_raster_gen crg_checker #(.NUM_CH(NUM_CH)) u_crg_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (run_bit),
    .scan_i    (scan_on),
    .cnt_x_i   (cnt_x),
    .cnt_y_i   (cnt_y),
    .frame_i   (frame_c),
    .disp_ul_i (disp_ul),
    .disp_lr_i (disp_lr),
    .sync_i    (sync_c),
    .ch_en_i   (ch_en),
    .ch_tl_i   (ch_tl),
    .ch_br_i   (ch_br),
    .hsync_i   (hsync_o),
    .vsync_i   (vsync_o),
    .de_i      (de_o),
    .win_i     (win_act_o),
    .pos_x_i   (pos_x_o),
    .pos_y_i   (pos_y_o)
);

// File: tb/corner_raster_gen_test.sv
`timescale 1ns/1ps
module corner_raster_gen_test;
    import crg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync_o;
    logic        vsync_o;
    logic        de_o;
    logic [2:0]  win_act_o;
    logic [12:0] pos_x_o;
    logic [12:0] pos_y_o;

    always #2 clk = ~clk;

    corner_raster_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .hsync_o   (hsync_o),
        .vsync_o   (vsync_o),
        .de_o      (de_o),
        .win_act_o (win_act_o),
        .pos_x_o   (pos_x_o),
        .pos_y_o   (pos_y_o)
    );

    int checks = 0;
    int fails  = 0;
    bit mon_on = 1'b0;
    bit done   = 1'b0;
    logic [31:0] exp_q [$];

    // Bench copy of what it has programmed.
    int fx, fy, ulx, uly, lrx, lry, hl, vl;
    int tlx [3];
    int tly [3];
    int brx [3];
    int bry [3];
    bit en  [3];

    function automatic logic [31:0] observed();
        return {pos_x_o, pos_y_o, hsync_o, vsync_o, de_o, win_act_o};
    endfunction

    function automatic bit inside_w(int x, int y, int ax, int ay, int bx, int by);
        return (x > ax) && (x <= bx) && (y > ay) && (y <= by);
    endfunction

    function automatic logic [31:0] model(int x, int y);
        logic [2:0] w;
        for (int i = 0; i < 3; i++) begin
            bit empty;
            empty = (tlx[i] == 0) && (tly[i] == 0) && (brx[i] == 0) && (bry[i] == 0);
            w[i] = en[i] && !empty && inside_w(x, y, tlx[i], tly[i], brx[i], bry[i]);
        end
        return {13'(x), 13'(y), 1'(x < hl), 1'(y < vl),
                1'(inside_w(x, y, ulx, uly, lrx, lry)), w};
    endfunction

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (mon_on && exp_q.size() > 0) begin
            logic [31:0] e;
            logic [31:0] g;
            string tag;
            e = exp_q.pop_front();
            g = observed();
            checks++;
            if (g !== e) begin
                fails++;
                if (g[31:6] !== e[31:6])      tag = "R3 position";
                else if (g[5:4] !== e[5:4])   tag = "R8 sync";
                else if (g[3] !== e[3])       tag = "R5 display";
                else                          tag = "R6/R7 channel";
                $display("FAIL %s actual=%h expected=%h", tag, g, e);
            end
        end
    end

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(int addr, int x, int y);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 8'(addr);
        wr_data = (32'(y) << 16) | 32'(x);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic set_ch(int n, int ax, int ay, int bx, int by);
        tlx[n] = ax; tly[n] = ay; brx[n] = bx; bry[n] = by;
        wr('h10 + 8 * n, ax, ay);
        wr('h14 + 8 * n, bx, by);
    endtask

    // R1 R2 R9: push predicted frames, write the run bit, compare.
    task automatic run_frames(logic [2:0] ch_bits, int n);
        int x = 0;
        int y = 0;
        en[0] = ch_bits[2];
        en[1] = ch_bits[1];
        en[2] = ch_bits[0];
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(model(x, y));
            if (x >= fx) begin
                x = 0;
                y = (y >= fy) ? 0 : y + 1;
            end else begin
                x++;
            end
        end
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 8'h00;
        wr_data = 32'h100 | 32'(ch_bits);
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        @(posedge clk);
        @(posedge clk);
        mon_on = 1'b1;
        while (exp_q.size() != 0) @(posedge clk);
        mon_on = 1'b0;
    endtask

    // R4 R10: clear run bit, outputs must go quiet and stay there.
    task automatic stop_and_check(logic [2:0] ch_bits);
        wr(0, 32'(ch_bits), 0);
        repeat (2) @(posedge clk);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(observed() == '0, "R4 halted outputs", observed(), '0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog R3 actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(observed() == '0, "R4 reset state", observed(), '0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(observed() == '0, "R10 idle after reset", observed(), '0);
        end

        // Setup A (R1): 10x6 frame, window x3..7 y2..4, ch2 empty (R7).
        fx = 9; fy = 5;
        wr('h04, fx, fy);
        ulx = 2; uly = 1; lrx = 7; lry = 4;
        wr('h08, ulx, uly);
        wr('h0C, lrx, lry);
        hl = 2; vl = 1;
        wr('h28, hl, vl);
        set_ch(0, 3, 2, 5, 3);
        set_ch(1, 0, 0, 0, 0);
        set_ch(2, 6, 1, 9, 5);
        run_frames(3'b111, 130);
        stop_and_check(3'b111);

        // Setup B (R6, R7): ch2 top-left zero but non-empty, ch3 disabled.
        set_ch(1, 0, 0, 2, 2);
        run_frames(3'b110, 60);
        stop_and_check(3'b110);

        // Setup C (R3, R8): 5x3 frame, no sync, only ch1 on.
        fx = 4; fy = 2;
        wr('h04, fx, fy);
        ulx = 0; uly = 0; lrx = 4; lry = 2;
        wr('h08, ulx, uly);
        wr('h0C, lrx, lry);
        hl = 0; vl = 0;
        wr('h28, hl, vl);
        set_ch(0, 0, 0, 4, 2);
        run_frames(3'b100, 30);
        stop_and_check(3'b100);

        finish_run();
    end

endmodule